// File: doc/BRIEF.md
# Channel Lock Bank

A bank of hardware mutexes shared by several command channels. Each channel drives one decoded 32-bit command word at a time, with a valid strobe and a ready return. The channel number is the position of the channel on the command port. Two kinds of command word touch the bank: one takes a lock, the other gives it back. Each names a lock by its index. Every other command word passes through at once, with no effect on the bank.

A channel that asks for a lock held by another channel is stalled. Its ready stays low until the lock comes free and the channel wins it. When several channels ask for the same free lock in one cycle, the lowest channel number wins.

Software has a register port with one address per lock. A read returns a status word showing whether the lock is taken and which channel holds it. Writing zero to a lock's address frees that lock, whoever holds it. This is the recovery path after a channel hangs while it holds a lock.

Top module: `chl_lock_bank`

## Requirements
- R1: A command word is a lock operation when bits 31:28 equal 14. Bit 24 set means release and bit 24 clear means acquire. The lock index is in bits IDX_W-1:0, where IDX_W = $clog2(NUM_LOCKS); it is 5 bits at the default. Any other command word has ready high in the same cycle and changes no lock.
- R2: An acquire of a free lock with no lower-numbered competitor has ready high in the same cycle. From the next cycle the lock is held by that channel.
- R3: An acquire of a lock held by another channel holds that channel's ready low. Ready rises in the first cycle in which the lock shows free and the channel is the lowest-numbered requester.
- R4: When several channels acquire one free lock in the same cycle, only the lowest-numbered channel sees ready high and becomes owner. The others stay stalled.
- R5: An acquire by the channel that already owns the lock completes in the same cycle and leaves the lock's state unchanged.
- R6: A release by the owner frees the lock from the next cycle, with owner field 0. A release by any other channel has ready high and leaves the state unchanged.
- R7: A read returns the status word of the selected lock on reg_rdata in the cycle after reg_rd. Bit 0 is the locked flag, bits 7:2 are the owner channel number, and all other bits are 0. reg_rdata holds its value while no read is made.
- R8: A software write of 0 to a lock's address frees that lock from the next cycle, whatever channel owns it. A nonzero write has no effect. If a channel is granted the lock in the same cycle as the write, the grant wins.
- R9: After reset every lock is free with owner field 0.
- R10: A lock operation whose index is NUM_LOCKS or above is accepted at once and has no effect. A read of such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_word | input | NUM_CH*32 | Command words, channel c in bits 32c+31:32c |
| cmd_valid | input | NUM_CH | Command valid per channel |
| cmd_ready | output | NUM_CH | Command accepted per channel; low while stalled |
| reg_sel | input | IDX_W | Lock index for the register port |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data; zero frees the lock |
| reg_rdata | output | 32 | Registered status word |

## Verification
The hardest case to reach from the ports is a three-way handoff. Several channels must keep asking for one lock while its owner releases it, and the grant must then pass to the next lowest channel on the exact cycle the lock shows free. The bench holds the valid strobes of all four channels across the release. It checks the ready vector cycle by cycle.

A second hard case is a software clear that lands on the same cycle as a channel's grant. The bench drives the clear and the grant on the same edge.

A sweep over every lock paired with every channel covers ownership, release by the owner and by a non-owner, and re-acquire by the owner.

// File: rtl/chl_pkg.sv
// Shared constants for the channel lock bank.
// Assumes 32-bit command words and a 6-bit owner field in the status word.
package chl_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned OWNER_W = 6;
    localparam logic [3:0]  LOCK_OPC = 4'd14;
    localparam int unsigned REL_BIT = 24;
endpackage

// File: rtl/chl_decode.sv
// Decodes one channel's command word into acquire/release strobes and a lock index.
// Assumes the word is only meaningful while valid is high.
module chl_decode #(
    parameter int IDX_W = 5
) (
    input  logic [chl_pkg::WORD_W-1:0] word,
    input  logic                       valid,
    output logic                       acq,
    output logic                       rel,
    output logic [IDX_W-1:0]           idx
);
    import chl_pkg::*;

    logic is_lock;
    logic unused_bits;

    // Recognise the lock opcode and split it by the release bit.
    always_comb begin
        is_lock = valid && (word[31:28] == LOCK_OPC);
        acq     = is_lock && !word[REL_BIT];
        rel     = is_lock &&  word[REL_BIT];
        idx     = word[IDX_W-1:0];
    end

    assign unused_bits = ^{word[27:25], word[23:IDX_W]};
endmodule

// File: rtl/chl_arbiter.sv
// Fixed-priority pick of the lowest-numbered requester for one lock.
// Assumes requests are already limited to a lock that is currently free.
module chl_arbiter #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] win
);
    // Isolate the lowest set request bit.
    always_comb begin
        win = req & (~req + NUM_CH'(1));
    end

    // Guard the winner vector against overlap or a winner that did not ask.
    always_comb begin
        // R4
        win_onehot_chk: assert ($onehot0(win));
        // R4
        win_subset_chk: assert ((win & ~req) == '0);
    end
endmodule

// File: rtl/chl_lock_slot.sv
// Ownership state for a single lock: locked flag and owner channel number.
// Assumes grant is one-hot or zero and only arrives while the lock is free.
module chl_lock_slot #(
    parameter int NUM_CH  = 4,
    parameter int OWNER_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  grant,
    input  logic               rel_hit,
    input  logic               sw_clr,
    output logic               locked,
    output logic [OWNER_W-1:0] owner
);
    logic [OWNER_W-1:0] gid;

    // Turn the one-hot grant into a channel number.
    always_comb begin
        gid = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (grant[c]) gid = OWNER_W'(c);
        end
    end

    // Update ownership; a grant takes precedence over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            owner  <= '0;
        end else if (|grant) begin
            locked <= 1'b1;
            owner  <= gid;
        end else if (rel_hit || sw_clr) begin
            locked <= 1'b0;
            owner  <= '0;
        end
    end

    // R2
    grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> !locked);
    // R9
    free_owner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (owner == '0));
    // R6
    held_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !rel_hit && !sw_clr) |=> (locked && $stable(owner)));
endmodule

// File: rtl/chl_lock_bank.sv
// Bank of NUM_LOCKS hardware mutexes shared by NUM_CH command channels.
// Lock commands arrive in the channels' command streams; a blocked acquire
// stalls its channel. A register port reads status and force-frees locks.
// Assumes NUM_CH <= 64 so channel numbers fit the 6-bit owner field.
module chl_lock_bank #(
    parameter  int NUM_CH    = 4,
    parameter  int NUM_LOCKS = 20,
    localparam int IDX_W     = $clog2(NUM_LOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH*32-1:0]  cmd_word,
    input  logic [NUM_CH-1:0]     cmd_valid,
    output logic [NUM_CH-1:0]     cmd_ready,
    input  logic [IDX_W-1:0]      reg_sel,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata
);
    import chl_pkg::*;

    logic [NUM_CH-1:0]  acq;
    logic [NUM_CH-1:0]  rel;
    logic [IDX_W-1:0]   idx [NUM_CH];
    logic [NUM_LOCKS-1:0] locked;
    logic [OWNER_W-1:0] owner [NUM_LOCKS];
    logic [NUM_CH-1:0]  blk   [NUM_LOCKS];
    logic [31:0]        stat  [NUM_LOCKS];

    genvar gc, gl;

    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
            chl_decode #(.IDX_W(IDX_W)) u_dec (
                .word  (cmd_word[gc*32 +: 32]),
                .valid (cmd_valid[gc]),
                .acq   (acq[gc]),
                .rel   (rel[gc]),
                .idx   (idx[gc])
            );
            // R3
            stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !cmd_ready[gc] |-> cmd_valid[gc]);
        end

        for (gl = 0; gl < NUM_LOCKS; gl++) begin : g_lock
            logic [NUM_CH-1:0] hit;
            logic [NUM_CH-1:0] req;
            logic [NUM_CH-1:0] win;
            logic              rel_hit;
            logic              sw_clr;

            // Sort each channel's request against this lock's state.
            always_comb begin
                rel_hit = 1'b0;
                for (int c = 0; c < NUM_CH; c++) begin
                    hit[c] = acq[c] && (idx[c] == IDX_W'(gl));
                    if (rel[c] && (idx[c] == IDX_W'(gl)) && locked[gl]
                        && (owner[gl] == OWNER_W'(c)))
                        rel_hit = 1'b1;
                end
                req    = locked[gl] ? '0 : hit;
                sw_clr = reg_wr && (reg_sel == IDX_W'(gl)) && (reg_wdata == '0);
            end

            chl_arbiter #(.NUM_CH(NUM_CH)) u_arb (
                .req (req),
                .win (win)
            );

            chl_lock_slot #(.NUM_CH(NUM_CH), .OWNER_W(OWNER_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .grant   (win),
                .rel_hit (rel_hit),
                .sw_clr  (sw_clr),
                .locked  (locked[gl]),
                .owner   (owner[gl])
            );

            // Mark channels whose acquire of this lock cannot complete now.
            always_comb begin
                for (int c = 0; c < NUM_CH; c++) begin
                    blk[gl][c] = hit[c] && (locked[gl] ? (owner[gl] != OWNER_W'(c)) : !win[c]);
                end
                stat[gl] = {{(32-OWNER_W-2){1'b0}}, owner[gl], 1'b0, locked[gl]};
            end
        end
    endgenerate

    // A channel is ready unless some lock blocks its acquire.
    always_comb begin
        cmd_ready = '1;
        for (int l = 0; l < NUM_LOCKS; l++) begin
            cmd_ready = cmd_ready & ~blk[l];
        end
    end

    // Registered status read; out-of-range indices read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= '0;
            for (int l = 0; l < NUM_LOCKS; l++) begin
                if (reg_sel == IDX_W'(l)) reg_rdata <= stat[l];
            end
        end
    end

    // R7
    rdata_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> ((reg_rdata[31:8] == '0) && !reg_rdata[1]));
endmodule

// File: tb/chl_lock_bank_tb.sv
`timescale 1ns/1ps
module chl_lock_bank_tb;
    localparam int NC = 4;
    localparam int NL = 20;
    localparam int IW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   bw [NC];
    logic [NC-1:0] bv = '0;
    logic [NC-1:0] cmd_ready;
    logic [IW-1:0] reg_sel = '0;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    int            n_run = 0;
    int            n_fail = 0;
    logic [31:0]   s;

    always #4 clk = ~clk;

    chl_lock_bank #(.NUM_CH(NC), .NUM_LOCKS(NL)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_word  ({bw[3], bw[2], bw[1], bw[0]}),
        .cmd_valid (bv),
        .cmd_ready (cmd_ready),
        .reg_sel   (reg_sel),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [31:0] acq(int l);
        return 32'hE000_0000 | 32'(l);
    endfunction
    function automatic logic [31:0] rel(int l);
        return 32'hE100_0000 | 32'(l);
    endfunction
    function automatic logic [31:0] st(int c);
        return 32'h1 | (32'(c) << 2);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Read a lock's status: strobe now, sample one cycle later.
    task automatic rd(int l, output logic [31:0] v);
        reg_sel = IW'(l);
        reg_rd = 1'b1;
        cyc();
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) bw[c] = '0;
        repeat (3) cyc();
        rst_n = 1'b1;

        // R9 reset state of every lock
        for (int l = 0; l < NL; l++) begin
            rd(l, s);
            chk("R9 reset status", s, 32'h0);
        end

        // R2 R5 R6 R7 sweep every lock against every channel
        for (int l = 0; l < NL; l++) begin
            for (int c = 0; c < NC; c++) begin
                int o;
                o = (c + 1) % NC;
                bv = '0; bv[c] = 1'b1; bw[c] = acq(l);
                #1 chk("R2 free acquire ready", 32'(cmd_ready), 32'hF);
                cyc(); bv = '0;
                rd(l, s);
                chk("R7 status after acquire", s, st(c));
                bv[o] = 1'b1; bw[o] = rel(l);
                #1 chk("R6 nonowner release ready", 32'(cmd_ready), 32'hF);
                cyc(); bv = '0;
                rd(l, s);
                chk("R6 nonowner release ignored", s, st(c));
                bv[c] = 1'b1; bw[c] = acq(l);
                #1 chk("R5 owner reacquire ready", 32'(cmd_ready), 32'hF);
                cyc(); bv = '0;
                rd(l, s);
                chk("R5 owner reacquire unchanged", s, st(c));
                bv[c] = 1'b1; bw[c] = rel(l);
                cyc(); bv = '0;
                rd(l, s);
                chk("R6 owner release frees", s, 32'h0);
            end
        end

        // R3 blocked acquire waits for the owner's release
        bv = '0; bv[1] = 1'b1; bw[1] = acq(3);
        cyc();
        bv[1] = 1'b0; bv[2] = 1'b1; bw[2] = acq(3);
        for (int k = 0; k < 3; k++) begin
            #1 chk("R3 stalled while held", 32'(cmd_ready), 32'hB);
            cyc();
        end
        bv[1] = 1'b1; bw[1] = rel(3);
        #1 chk("R3 stalled during release cycle", 32'(cmd_ready), 32'hB);
        cyc(); bv[1] = 1'b0;
        #1 chk("R3 ready once free", 32'(cmd_ready), 32'hF);
        cyc(); bv = '0;
        rd(3, s);
        chk("R3 new owner", s, st(2));
        bv[2] = 1'b1; bw[2] = rel(3); cyc(); bv = '0;

        // R4 four-way contest and handoff
        for (int c = 0; c < NC; c++) bw[c] = acq(5);
        bv = 4'hF;
        #1 chk("R4 lowest wins", 32'(cmd_ready), 32'h1);
        cyc(); bv[0] = 1'b0;
        #1 chk("R4 losers stall", 32'(cmd_ready), 32'h1);
        cyc(); bv[0] = 1'b1; bw[0] = rel(5);
        #1 chk("R4 stall across release", 32'(cmd_ready), 32'h1);
        cyc(); bv[0] = 1'b0;
        #1 chk("R4 next lowest wins", 32'(cmd_ready), 32'h3);
        cyc(); bv[1] = 1'b0;
        #1 chk("R4 remaining stall", 32'(cmd_ready), 32'h3);
        bv = '0;
        rd(5, s);
        chk("R4 owner after handoff", s, st(1));
        bv[1] = 1'b1; bw[1] = rel(5); cyc(); bv = '0;

        // R1 non-lock commands pass and change nothing
        bw[0] = 32'h1000_0003; bw[1] = 32'hD000_0003;
        bw[2] = 32'hF100_0003; bw[3] = 32'h0000_0000;
        bv = 4'hF;
        #1 chk("R1 non-lock ready", 32'(cmd_ready), 32'hF);
        cyc(); bv = '0;
        rd(3, s);
        chk("R1 non-lock no effect", s, 32'h0);

        // R10 out-of-range index
        bv[2] = 1'b1; bw[2] = acq(25);
        #1 chk("R10 out-of-range ready", 32'(cmd_ready), 32'hF);
        cyc(); bv = '0;
        rd(25, s);
        chk("R10 out-of-range read", s, 32'h0);
        for (int l = 0; l < NL; l++) begin
            rd(l, s);
            chk("R10 no lock touched", s, 32'h0);
        end

        // R8 software force-free, nonzero write ignored
        bv[3] = 1'b1; bw[3] = acq(7); cyc(); bv = '0;
        reg_wr = 1'b1; reg_sel = 5'd7; reg_wdata = 32'h5;
        cyc(); reg_wr = 1'b0;
        rd(7, s);
        chk("R8 nonzero write ignored", s, st(3));
        bv[2] = 1'b1; bw[2] = acq(7);
        #1 chk("R8 blocked before clear", 32'(cmd_ready), 32'hB);
        reg_wr = 1'b1; reg_sel = 5'd7; reg_wdata = 32'h0;
        cyc(); reg_wr = 1'b0;
        #1 chk("R8 ready after clear", 32'(cmd_ready), 32'hF);
        cyc(); bv = '0;
        rd(7, s);
        chk("R8 waiter owns after clear", s, st(2));
        reg_wr = 1'b1; reg_sel = 5'd7; reg_wdata = 32'h0;
        cyc(); reg_wr = 1'b0;
        rd(7, s);
        chk("R8 clear any owner", s, 32'h0);
        bv[1] = 1'b1; bw[1] = acq(9);
        reg_wr = 1'b1; reg_sel = 5'd9; reg_wdata = 32'h0;
        cyc(); bv = '0; reg_wr = 1'b0;
        rd(9, s);
        chk("R8 grant beats same-cycle clear", s, st(1));

        // R7 rdata holds without a read
        cyc(); cyc();
        chk("R7 rdata holds", reg_rdata, st(1));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule